// File: doc/BRIEF.md
# Serial Byte Receiver with Deferred Overrun Reporting

This block takes an asynchronous serial line carrying eight-bit characters (one start bit, eight data bits sent least significant bit first, one stop bit, no parity) and presents each completed character to a processor through a small register bus. The line is sampled on a tick that fires once every `baud_div` clock cycles, and each bit lasts sixteen ticks. A start bit is confirmed by a second low sample half a bit after the falling edge. Any received character whose stop bit reads low is flagged, either as a framing error or, when every data bit was also zero, as a break.

A completed character is held in a one-byte data register. If another character completes before software has read that register, the held byte is kept. The overrun is not shown at once. Software first reads the valid byte as normal. Only then does the status report the overrun, together with the break flag when the lost character was a break, and the data-available bit comes back on as a marker. A further read of the data register retires the error. The data register itself changes only when a new character completes.

The bus has three addresses: 0 reads the data register, 1 reads status, and 2 reads or writes control. A single interrupt line is raised by data-available when its enable bit is set, and by any visible error flag whatever that enable holds.

Top module: `uart_rx_ovr`

## Requirements
- R1: A well-formed character (low start, eight data bits LSB first, high stop, each bit 16 ticks of `baud_div` clocks) loads its data into the register read at address 0 and sets status bit 0 (data available).
- R2: Control bit 0 at address 2 enables the data-available interrupt. With it set, `irq_o` is high while status bit 0 is set. With it clear and no error visible, `irq_o` stays low.
- R3: A character with a low stop bit and nonzero data sets status bit 1 (framing error) and raises `irq_o` whatever the enable holds. Reading address 0 clears it.
- R4: A character with a low stop bit and all data bits zero sets status bit 2 (break) and leaves bit 1 clear.
- R5: A low pulse on the line that has already returned high at the mid-start sample produces no character and leaves status at zero.
- R6: If a character completes while status bit 0 is set, the held byte is not replaced and status bit 3 (overrun) stays clear until that byte is read.
- R7: Reading the held byte after an overrun sets status bit 3 and bit 0 again. Bit 2 is also set when the lost character was a break. `irq_o` is high.
- R8: The next read of address 0 after that clears status bits 0, 2 and 3 and drops `irq_o`.
- R9: Reading status has no side effect. The data register changes only when a new character completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| baud_div | input | 16 | Clock cycles per oversampling tick (0 acts as 1) |
| rx_i | input | 1 | Serial line, idle high |
| bus_addr | input | 2 | Register address: 0 data, 1 status, 2 control |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe (control register only) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_o | output | 1 | Interrupt request |

## Verification
Alternating, mixed, all-ones and all-zero bytes with a high stop bit show that data and bit order arrive intact and that an all-zero byte alone is not a break. The same stop bit made low with nonzero data and then with zero data separates framing error from break. Two characters sent back to back without a read, once ending in an ordinary byte and once in a break, show when the overrun and break bits are hidden, revealed and cleared. A short glitch checks rejection of a false start, and a byte after the overrun sequence shows that the data register loads normally again.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W = 8;
  localparam int OSR    = 16;
  localparam int OSR_W  = $clog2(OSR);
  localparam int BIDX_W = $clog2(DATA_W);
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD
  } rx_state_e;

  typedef struct packed {
    logic ovr;
    logic brk;
    logic ferr;
    logic rda;
  } rx_status_t;

  // classify a stop-bit sample: returns {ferr, brk}
  function automatic logic [1:0] stop_class(input logic stop_bit,
                                             input logic [DATA_W-1:0] d);
    logic zero;
    zero = (d == '0);
    return {!stop_bit && !zero, !stop_bit && zero};
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(input rx_status_t s);
    return {{(DATA_W-4){1'b0}}, s.ovr, s.brk, s.ferr, s.rda};
  endfunction
endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign tick    = (cnt_inc >= {1'b0, baud_div});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_inc[DIV_W-1:0];
  end
endmodule

// File: rtl/rx_bit_engine.sv
module rx_bit_engine
  import uart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_i,
  output logic              char_done,
  output logic [DATA_W-1:0] char_data,
  output logic              char_ferr,
  output logic              char_brk
);
  localparam logic [OSR_W-1:0]  LAST = OSR_W'(OSR - 1);
  localparam logic [OSR_W-1:0]  MID  = OSR_W'(OSR / 2 - 1);
  localparam logic [BIDX_W-1:0] TOP  = BIDX_W'(DATA_W - 1);

  logic [1:0]        sync_q;
  logic              rx_s;
  rx_state_e         st_q;
  logic [OSR_W-1:0]  os_q;
  logic [BIDX_W-1:0] bit_q;
  logic [DATA_W-1:0] sh_q;
  logic [1:0]        cls;

  assign rx_s = sync_q[1];
  assign cls  = stop_class(rx_s, sh_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= 2'b11;
      st_q      <= RX_IDLE;
      os_q      <= '0;
      bit_q     <= '0;
      sh_q      <= '0;
      char_done <= 1'b0;
      char_data <= '0;
      char_ferr <= 1'b0;
      char_brk  <= 1'b0;
    end else begin
      sync_q    <= {sync_q[0], rx_i};
      char_done <= 1'b0;
      case (st_q)
        RX_IDLE:
          if (tick && !rx_s) begin
            st_q <= RX_START;
            os_q <= '0;
          end
        RX_START:
          if (tick) begin
            if (os_q == MID) begin
              st_q  <= rx_s ? RX_IDLE : RX_DATA;
              os_q  <= '0;
              bit_q <= '0;
            end else os_q <= os_q + 1'b1;
          end
        RX_DATA:
          if (tick) begin
            if (os_q == LAST) begin
              sh_q <= {rx_s, sh_q[DATA_W-1:1]};
              os_q <= '0;
              if (bit_q == TOP) st_q <= RX_STOP;
              else              bit_q <= bit_q + 1'b1;
            end else os_q <= os_q + 1'b1;
          end
        RX_STOP:
          if (tick) begin
            if (os_q == LAST) begin
              char_done <= 1'b1;
              char_data <= sh_q;
              char_ferr <= cls[1];
              char_brk  <= cls[0];
              os_q      <= '0;
              st_q      <= rx_s ? RX_IDLE : RX_HOLD;
            end else os_q <= os_q + 1'b1;
          end
        RX_HOLD:
          if (rx_s) st_q <= RX_IDLE;
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> !char_done); // R1
  AST_BRK_NOT_FERR: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |-> !(char_ferr && char_brk)); // R4
endmodule

// File: rtl/rx_regs.sv
module rx_regs
  import uart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_done,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_ferr,
  input  logic              char_brk,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic [DATA_W-1:0] data_q, data_n;
  rx_status_t        st_q, st_n;
  logic              pend_q, pend_n, pbrk_q, pbrk_n, ie_q;
  logic              rd_data, rd_stat;
  logic [DATA_W-1:0] status_w;

  assign rd_data  = bus_rd && (bus_addr == ADDR_DATA);
  assign rd_stat  = bus_rd && (bus_addr == ADDR_STAT);
  assign status_w = pack_status(st_q);

  always_comb begin
    data_n = data_q;
    st_n   = st_q;
    pend_n = pend_q;
    pbrk_n = pbrk_q;
    if (rd_data) begin
      if (pend_q) begin
        st_n   = '{ovr: 1'b1, brk: pbrk_q, ferr: 1'b0, rda: 1'b1};
        pend_n = 1'b0;
        pbrk_n = 1'b0;
      end else begin
        st_n = '0;
      end
    end
    if (char_done) begin
      if (!st_n.rda) begin
        data_n    = char_data;
        st_n.rda  = 1'b1;
        st_n.ferr = char_ferr;
        st_n.brk  = char_brk;
      end else begin
        pend_n = 1'b1;
        pbrk_n = pbrk_n | char_brk;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      st_q   <= '0;
      pend_q <= 1'b0;
      pbrk_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      data_q <= data_n;
      st_q   <= st_n;
      pend_q <= pend_n;
      pbrk_q <= pbrk_n;
      if (bus_wr && bus_addr == ADDR_CTRL) ie_q <= bus_wdata[0];
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_DATA: bus_rdata = data_q;
      ADDR_STAT: bus_rdata = status_w;
      ADDR_CTRL: bus_rdata = {{(DATA_W-1){1'b0}}, ie_q};
      default:   bus_rdata = '0;
    endcase
  end

  assign irq_o = (st_q.rda && ie_q) || st_q.ferr || st_q.brk || st_q.ovr;

  AST_KEEP_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && st_q.rda && !rd_data) |=> $stable(data_q)); // R6
  AST_HIDE_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && st_q.rda && !st_q.ovr && !rd_data) |=> !st_q.ovr); // R6
  AST_REVEAL_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && pend_q) |=> (st_q.ovr && st_q.rda && irq_o)); // R7
  AST_CLEAR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !pend_q && !char_done) |=> (status_w == '0)); // R8
  AST_STAT_NOSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !char_done) |=> ($stable(status_w) && $stable(data_q))); // R9
endmodule

// File: rtl/uart_rx_ovr.sv
module uart_rx_ovr
  import uart_rx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             rx_i,
  input  logic [1:0]       bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             irq_o
);
  logic              tick;
  logic              char_done, char_ferr, char_brk;
  logic [DATA_W-1:0] char_data;

  rx_tick_gen #(.DIV_W(DIV_W)) i_tick (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .tick(tick)
  );

  rx_bit_engine i_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_i(rx_i),
    .char_done(char_done), .char_data(char_data),
    .char_ferr(char_ferr), .char_brk(char_brk)
  );

  rx_regs i_regs (
    .clk(clk), .rst_n(rst_n),
    .char_done(char_done), .char_data(char_data),
    .char_ferr(char_ferr), .char_brk(char_brk),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );
endmodule

// File: tb/test_uart_rx_ovr.sv
module test_uart_rx_ovr;
  localparam int DIV = 2;
  localparam int BITC = 16 * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [15:0] baud_div = 16'(DIV);
  logic       rx_i = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_rx_ovr i_uart_rx_ovr (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .rx_i(rx_i),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // {data[7:0], stop bit, expected status[7:0]}; status: b0 avail, b1 ferr, b2 brk, b3 ovr
  localparam logic [16:0] VEC [6] = '{
    {8'h55, 1'b1, 8'h01},
    {8'hA3, 1'b1, 8'h01},
    {8'hFF, 1'b1, 8'h01},
    {8'h00, 1'b1, 8'h01},
    {8'h81, 1'b0, 8'h03},
    {8'h00, 1'b0, 8'h05}
  };

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic stop);
    @(negedge clk) rx_i = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_i = d[i];
      repeat (BITC) @(negedge clk);
    end
    rx_i = stop;
    repeat (BITC) @(negedge clk);
    if (!stop) repeat (BITC) @(negedge clk);
    rx_i = 1'b1;
    repeat (2 * BITC) @(negedge clk);
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    bus_wdata = v;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v, v2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset state
    bus_read(2'd1, v);
    check("R1 reset status", v, 8'h00);
    check("R2 reset irq", irq_o, 0);

    // vector table: R1 data, R3 ferr, R4 break
    for (int k = 0; k < 6; k++) begin
      send(VEC[k][16:9], VEC[k][8]);
      bus_read(2'd1, v);
      check("R1/R3/R4 status", v, VEC[k][7:0]);
      bus_read(2'd0, v);
      check("R1 data", v, VEC[k][16:9]);
      bus_read(2'd1, v);
      check("R3 status cleared after read", v, 8'h00);
    end

    // R2: data-available irq gated by enable
    send(8'h5A, 1'b1);
    check("R2 irq off when disabled", irq_o, 0);
    bus_write(2'd2, 8'h01);
    bus_read(2'd2, v);
    check("R2 control readback", v, 8'h01);
    check("R2 irq on when enabled", irq_o, 1);
    bus_read(2'd0, v);
    check("R2 irq drops after data read", irq_o, 0);
    bus_write(2'd2, 8'h00);

    // R3: framing error raises irq with enable clear
    send(8'h40, 1'b0);
    check("R3 irq from framing error", irq_o, 1);
    bus_read(2'd0, v);
    check("R3 irq cleared", irq_o, 0);

    // R5: false start
    @(negedge clk) rx_i = 1'b0;
    repeat (3 * DIV) @(negedge clk);
    rx_i = 1'b1;
    repeat (2 * BITC) @(negedge clk);
    bus_read(2'd1, v);
    check("R5 false start ignored", v, 8'h00);

    // R6..R8: overrun by ordinary byte
    send(8'h11, 1'b1);
    send(8'h22, 1'b1);
    bus_read(2'd1, v);
    check("R6 overrun hidden", v, 8'h01);
    bus_read(2'd1, v2);
    check("R9 status read repeatable", v2, v);
    bus_read(2'd0, v);
    check("R6 valid byte kept", v, 8'h11);
    bus_read(2'd1, v);
    check("R7 overrun revealed", v, 8'h09);
    check("R7 irq on overrun", irq_o, 1);
    bus_read(2'd0, v);
    check("R9 data unchanged by overrun", v, 8'h11);
    bus_read(2'd1, v);
    check("R8 overrun cleared", v, 8'h00);
    check("R8 irq cleared", irq_o, 0);

    // R7: overrun by break
    send(8'h33, 1'b1);
    send(8'h00, 1'b0);
    bus_read(2'd1, v);
    check("R6 break overrun hidden", v, 8'h01);
    bus_read(2'd0, v);
    check("R6 valid byte kept (break)", v, 8'h33);
    bus_read(2'd1, v);
    check("R7 overrun with break", v, 8'h0D);
    bus_read(2'd0, v);
    bus_read(2'd1, v);
    check("R8 break overrun cleared", v, 8'h00);

    // R9: next complete word loads normally
    send(8'h44, 1'b1);
    bus_read(2'd0, v);
    check("R9 new word loads", v, 8'h44);

    done = 1'b1;
    finish_run();
  end
endmodule